// File: doc/BRIEF.md
# Bridge Transaction Claim Controller

This block sits at the decision point of a two-sided bus bridge. Each time a cycle starts on either side, it looks at the cycle's address, command and originating side. It checks the address against two address windows held in registers: one for the range that lives below the bridge and one for the range reachable above it. From that it decides whether the bridge takes the cycle. A cycle aimed at the side it came from, or at no known range, is left alone. A cycle that an initiator upstream sends to no range therefore ends in a master abort on that bus.

When the bridge takes a cycle, the block chooses how that cycle finishes. A memory write is accepted at once as posted. Every other command is answered with a retry and held in a single delayed-request slot. Either way, the block issues a request to send the cycle to the opposite side. The far side later reports that the forwarded cycle completed, or that it ended in a master abort. When the initiator repeats the identical cycle after that, the block ends the repeat normally, or hands back the abort, and then frees the slot.

All responses are registered. They appear in the cycle after the start strobe and stay for that one cycle only.

Top module: `brg_claim_ctrl`

## Requirements
- R1: An upstream cycle (side 0) with an address inside the downstream window is claimed: `sel_up` is 1 in the next cycle and `sel_dn` is 0.
- R2: An upstream cycle with an address outside the downstream window is not claimed: no select, no posted, retry, done or abort response, and no forward request. This is the case that leaves the initiator to master-abort.
- R3: A downstream cycle (side 1) with an address inside the downstream window targets its own side and is not claimed.
- R4: A downstream cycle with an address outside the downstream window and inside the upstream window is claimed with `sel_dn`. A downstream cycle that is in neither window is not claimed.
- R5: A claimed cycle with command 4'h7 (memory write) is posted. It gives `post_ok` with no retry and a forward request whose `fwd_dest` is the opposite side, and it does not touch the delayed slot.
- R6: A claimed cycle with any other command (for example 4'h2 I/O read, 4'h6 memory read, 4'hA configuration read) gives `retry` when the slot is free. It also gives a forward request carrying the cycle's address and command, and the slot holds that cycle.
- R7: A repeat of the stored cycle before the far side has reported completion gets `retry` and no new forward request.
- R8: Once `far_done` has been seen for the stored cycle, a repeat with the same address, command and side gets `done_ok`, with no retry. The slot then becomes free, so the next delayed cycle is forwarded.
- R9: While the slot is busy, a claimed non-postable cycle that differs from the stored one in address, command or side gets `retry` and no forward request.
- R10: If `far_mabort` is reported for the stored cycle, the matching repeat gets `mabort_ret`, with no retry, and the slot becomes free.
- R11: A window covers base <= address <= limit, including both ends. A window whose limit is below its base matches no address.
- R12: While reset is held, and in the cycle after it, every response output is 0 and the slot is free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Strobe: a new cycle starts this clock |
| cyc_addr | input | AW | Address of the starting cycle |
| cyc_cmd | input | CW | Bus command of the starting cycle |
| cyc_side | input | 1 | Originating side: 0 upstream, 1 downstream |
| dn_base | input | AW | Lowest address of the downstream window |
| dn_limit | input | AW | Highest address of the downstream window |
| up_base | input | AW | Lowest address of the upstream window |
| up_limit | input | AW | Highest address of the upstream window |
| far_done | input | 1 | Forwarded delayed cycle completed on the far side |
| far_mabort | input | 1 | Forwarded delayed cycle ended in master abort on the far side |
| sel_up | output | 1 | Claim by device-select on the upstream side |
| sel_dn | output | 1 | Claim by device-select on the downstream side |
| post_ok | output | 1 | Claimed cycle accepted as posted |
| retry | output | 1 | Claimed cycle answered with retry |
| done_ok | output | 1 | Repeat of the delayed cycle ends normally |
| mabort_ret | output | 1 | Repeat of the delayed cycle receives master abort |
| fwd_req | output | 1 | Request to run the cycle on the opposite side |
| fwd_dest | output | 1 | Side the forwarded cycle goes to |
| fwd_addr | output | AW | Address of the forwarded cycle |
| fwd_cmd | output | CW | Command of the forwarded cycle |

## Verification
Several properties are checked by the assertions on every clock: the bridge never selects on both sides at once, each claim gets exactly one kind of termination, a forward request only comes with a claim, and the slot only loads when it is free and only frees from a completed or aborted state. Some behaviours can only be shown by the bench's scenarios, because they depend on a chain of cycles. These are that the right response follows a given address against the windows and their edges, that a repeat finishes only after the far side reports, that an abort returns on the repeat, and that a different cycle is held off while the slot is busy.

// File: rtl/brg_pkg.sv
package brg_pkg;

    parameter int unsigned BRG_AW = 16;
    parameter int unsigned BRG_CW = 4;

    // Only this command is accepted as posted
    localparam logic [BRG_CW-1:0] CMD_MEM_WR = 4'h7;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2,
        SLOT_ABORT = 2'd3
    } slot_st_e;

    typedef struct packed {
        logic sel_up;
        logic sel_dn;
        logic post;
        logic retry;
        logic done;
        logic mab;
        logic fwd;
    } rsp_t;

    localparam rsp_t RSP_NONE = '{default: 1'b0};

endpackage

// File: rtl/brg_decode.sv
module brg_decode #(
    parameter int AW = brg_pkg::BRG_AW
) (
    input  logic [AW-1:0] addr,
    input  logic          side,
    input  logic [AW-1:0] dn_base,
    input  logic [AW-1:0] dn_limit,
    input  logic [AW-1:0] up_base,
    input  logic [AW-1:0] up_limit,
    output logic          hit
);
    logic in_dn, in_up;

    // inclusive window; limit below base gives no match
    always_comb begin
        in_dn = (dn_limit >= dn_base) && (addr >= dn_base) && (addr <= dn_limit);
        in_up = (up_limit >= up_base) && (addr >= up_base) && (addr <= up_limit);
        if (!side) hit = in_dn;
        else       hit = !in_dn && in_up;
    end
endmodule

// File: rtl/brg_dslot.sv
module brg_dslot
    import brg_pkg::*;
#(
    parameter int AW = BRG_AW,
    parameter int CW = BRG_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          release_slot,
    input  logic          far_done,
    input  logic          far_mabort,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] cmd,
    input  logic          side,
    output slot_st_e      state,
    output logic          match
);
    logic [AW-1:0] s_addr;
    logic [CW-1:0] s_cmd;
    logic          s_side;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SLOT_IDLE;
            s_addr <= '0;
            s_cmd  <= '0;
            s_side <= 1'b0;
        end else begin
            unique case (state)
                SLOT_IDLE: if (capture) begin
                    state  <= SLOT_WAIT;
                    s_addr <= addr;
                    s_cmd  <= cmd;
                    s_side <= side;
                end
                SLOT_WAIT: begin
                    if (far_mabort)    state <= SLOT_ABORT;
                    else if (far_done) state <= SLOT_READY;
                end
                SLOT_READY, SLOT_ABORT: if (release_slot) state <= SLOT_IDLE;
                default: state <= SLOT_IDLE;
            endcase
        end
    end

    assign match = (state != SLOT_IDLE) && (addr == s_addr) &&
                   (cmd == s_cmd) && (side == s_side);

    a_r6_capture_when_free: assert property (@(posedge clk) disable iff (rst)
        capture |-> state == SLOT_IDLE);
    a_r8_release_after_far: assert property (@(posedge clk) disable iff (rst)
        release_slot |-> (state == SLOT_READY || state == SLOT_ABORT));
    a_r10_abort_from_wait: assert property (@(posedge clk) disable iff (rst)
        (state == SLOT_WAIT && far_mabort) |=> state == SLOT_ABORT);
    a_r7_ready_holds: assert property (@(posedge clk) disable iff (rst)
        (state == SLOT_READY && !release_slot) |=> state == SLOT_READY);
endmodule

// File: rtl/brg_claim_ctrl.sv
module brg_claim_ctrl
    import brg_pkg::*;
#(
    parameter int AW = BRG_AW,
    parameter int CW = BRG_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_start,
    input  logic [AW-1:0] cyc_addr,
    input  logic [CW-1:0] cyc_cmd,
    input  logic          cyc_side,
    input  logic [AW-1:0] dn_base,
    input  logic [AW-1:0] dn_limit,
    input  logic [AW-1:0] up_base,
    input  logic [AW-1:0] up_limit,
    input  logic          far_done,
    input  logic          far_mabort,
    output logic          sel_up,
    output logic          sel_dn,
    output logic          post_ok,
    output logic          retry,
    output logic          done_ok,
    output logic          mabort_ret,
    output logic          fwd_req,
    output logic          fwd_dest,
    output logic [AW-1:0] fwd_addr,
    output logic [CW-1:0] fwd_cmd
);
    logic     hit, match, claim, postable, capture, release_slot;
    slot_st_e sst;
    rsp_t     nxt, cur;

    brg_decode #(.AW(AW)) u_dec (
        .addr(cyc_addr), .side(cyc_side),
        .dn_base(dn_base), .dn_limit(dn_limit),
        .up_base(up_base), .up_limit(up_limit),
        .hit(hit)
    );

    brg_dslot #(.AW(AW), .CW(CW)) u_slot (
        .clk(clk), .rst(rst),
        .capture(capture), .release_slot(release_slot),
        .far_done(far_done), .far_mabort(far_mabort),
        .addr(cyc_addr), .cmd(cyc_cmd), .side(cyc_side),
        .state(sst), .match(match)
    );

    always_comb begin
        claim    = cyc_start && hit;
        postable = (cyc_cmd == CMD_MEM_WR);
        nxt      = RSP_NONE;
        if (claim) begin
            nxt.sel_up = !cyc_side;
            nxt.sel_dn = cyc_side;
            if (postable) begin
                nxt.post = 1'b1;
                nxt.fwd  = 1'b1;
            end else if (match && sst == SLOT_READY) begin
                nxt.done = 1'b1;
            end else if (match && sst == SLOT_ABORT) begin
                nxt.mab = 1'b1;
            end else begin
                nxt.retry = 1'b1;
                nxt.fwd   = (sst == SLOT_IDLE);
            end
        end
        capture      = claim && !postable && (sst == SLOT_IDLE);
        release_slot = nxt.done || nxt.mab;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= RSP_NONE;
            fwd_dest <= 1'b0;
            fwd_addr <= '0;
            fwd_cmd  <= '0;
        end else begin
            cur <= nxt;
            if (nxt.fwd) begin
                fwd_dest <= !cyc_side;
                fwd_addr <= cyc_addr;
                fwd_cmd  <= cyc_cmd;
            end
        end
    end

    assign sel_up     = cur.sel_up;
    assign sel_dn     = cur.sel_dn;
    assign post_ok    = cur.post;
    assign retry      = cur.retry;
    assign done_ok    = cur.done;
    assign mabort_ret = cur.mab;
    assign fwd_req    = cur.fwd;

    a_r1_one_side: assert property (@(posedge clk) disable iff (rst)
        !(sel_up && sel_dn));
    a_r5_single_ending: assert property (@(posedge clk) disable iff (rst)
        (sel_up || sel_dn) |-> $countones({post_ok, retry, done_ok, mabort_ret}) == 1);
    a_r2_fwd_needs_claim: assert property (@(posedge clk) disable iff (rst)
        fwd_req |-> (sel_up || sel_dn));
    a_r2_no_ending_unclaimed: assert property (@(posedge clk) disable iff (rst)
        !(sel_up || sel_dn) |-> !(post_ok || retry || done_ok || mabort_ret));
    a_r5_dest_opposite: assert property (@(posedge clk) disable iff (rst)
        fwd_req |-> (fwd_dest == sel_up));
    a_r12_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(sel_up || sel_dn || fwd_req));
endmodule

// File: tb/brg_claim_ctrl_test.sv
module brg_claim_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cyc_start = 1'b0;
    logic [AW-1:0] cyc_addr = '0;
    logic [CW-1:0] cyc_cmd = '0;
    logic          cyc_side = 1'b0;
    logic [AW-1:0] dn_base = 16'h1000, dn_limit = 16'h1FFF;
    logic [AW-1:0] up_base = 16'h8000, up_limit = 16'hFFFF;
    logic          far_done = 1'b0, far_mabort = 1'b0;
    logic          sel_up, sel_dn, post_ok, retry, done_ok, mabort_ret, fwd_req, fwd_dest;
    logic [AW-1:0] fwd_addr;
    logic [CW-1:0] fwd_cmd;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int            m_st = 0;  // 0 free, 1 waiting, 2 ready, 3 aborted
    logic [AW-1:0] m_addr;
    logic [CW-1:0] m_cmd;
    logic          m_side;
    logic e_up = 0, e_dn = 0, e_post = 0, e_retry = 0, e_done = 0, e_mab = 0, e_fwd = 0, e_dest = 0;
    logic [AW-1:0] e_faddr = '0;
    logic [CW-1:0] e_fcmd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brg_claim_ctrl #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
        .cyc_cmd(cyc_cmd), .cyc_side(cyc_side), .dn_base(dn_base), .dn_limit(dn_limit),
        .up_base(up_base), .up_limit(up_limit), .far_done(far_done), .far_mabort(far_mabort),
        .sel_up(sel_up), .sel_dn(sel_dn), .post_ok(post_ok), .retry(retry),
        .done_ok(done_ok), .mabort_ret(mabort_ret), .fwd_req(fwd_req), .fwd_dest(fwd_dest),
        .fwd_addr(fwd_addr), .fwd_cmd(fwd_cmd)
    );

    function automatic bit in_win(logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] l);
        return (l >= b) && (a >= b) && (a <= l);
    endfunction

    task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk({tag, " R1/R4 sel_up"}, AW'(sel_up), AW'(e_up));
        chk({tag, " R1/R4 sel_dn"}, AW'(sel_dn), AW'(e_dn));
        chk({tag, " R5 post_ok"}, AW'(post_ok), AW'(e_post));
        chk({tag, " R6/R7/R9 retry"}, AW'(retry), AW'(e_retry));
        chk({tag, " R8 done_ok"}, AW'(done_ok), AW'(e_done));
        chk({tag, " R10 mabort_ret"}, AW'(mabort_ret), AW'(e_mab));
        chk({tag, " R6/R7 fwd_req"}, AW'(fwd_req), AW'(e_fwd));
        if (e_fwd) begin
            chk({tag, " R5 fwd_dest"}, AW'(fwd_dest), AW'(e_dest));
            chk({tag, " R6 fwd_addr"}, fwd_addr, e_faddr);
            chk({tag, " R6 fwd_cmd"}, AW'(fwd_cmd), AW'(e_fcmd));
        end
    endtask

    // one clock: check the previous response, drive new inputs, predict the response
    task automatic step(string tag, bit st, logic [AW-1:0] a, logic [CW-1:0] c, bit sd, bit fd, bit fm);
        bit hit, post, match;
        int old;
        @(negedge clk);
        compare(tag);
        cyc_start = st; cyc_addr = a; cyc_cmd = c; cyc_side = sd;
        far_done = fd; far_mabort = fm;
        hit   = st && (sd ? (!in_win(a, dn_base, dn_limit) && in_win(a, up_base, up_limit))
                          : in_win(a, dn_base, dn_limit));
        post  = (c == 4'h7);
        old   = m_st;
        match = (old != 0) && a == m_addr && c == m_cmd && sd == m_side;
        e_up    = hit && !sd;
        e_dn    = hit && sd;
        e_post  = hit && post;
        e_done  = hit && !post && match && old == 2;
        e_mab   = hit && !post && match && old == 3;
        e_retry = hit && !post && !e_done && !e_mab;
        e_fwd   = hit && (post || old == 0);
        if (e_fwd) begin
            e_dest = !sd; e_faddr = a; e_fcmd = c;
        end
        if (old == 1) begin
            if (fm) m_st = 3;
            else if (fd) m_st = 2;
        end
        if (hit && !post && old == 0) begin
            m_st = 1; m_addr = a; m_cmd = c; m_side = sd;
        end
        if (e_done || e_mab) m_st = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [AW-1:0] pool [8];
        logic [CW-1:0] cmds [4];
        pool = '{16'h0FFF, 16'h1000, 16'h1800, 16'h1FFF, 16'h2000, 16'h8000, 16'hFFFF, 16'h4000};
        cmds = '{4'h2, 4'h6, 4'h7, 4'hA};
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        compare("R12 in reset");
        @(negedge clk); rst = 1'b0;
        // R12: first cycle out of reset
        step("R12 after reset", 0, 0, 0, 0, 0, 0);
        // R1/R5: posted write upstream at window base
        step("R5 post", 1, 16'h1000, 4'h7, 0, 0, 0);
        // R2: upstream miss just below base
        step("R2 miss", 1, 16'h0FFF, 4'h6, 0, 0, 0);
        // R3: downstream cycle to its own side, at limit
        step("R3 own side", 1, 16'h1FFF, 4'h6, 1, 0, 0);
        // R4: downstream in neither window
        step("R4 nowhere", 1, 16'h4000, 4'h6, 1, 0, 0);
        // R6: delayed read captured
        step("R6 capture", 1, 16'h1800, 4'h6, 0, 0, 0);
        // R7: repeat too early
        step("R7 early repeat", 1, 16'h1800, 4'h6, 0, 0, 0);
        // R9: other cycle while busy (command differs)
        step("R9 busy other", 1, 16'h1800, 4'hA, 0, 0, 0);
        // R4: downstream to upstream window, busy -> retry
        step("R4 up claim", 1, 16'h8000, 4'h2, 1, 0, 0);
        step("R8 far done", 0, 0, 0, 0, 1, 0);
        // R9: side differs, not a repeat
        step("R9 side differs", 1, 16'h1800, 4'h6, 1, 0, 0);
        // R8: the repeat completes
        step("R8 repeat done", 1, 16'h1800, 4'h6, 0, 0, 0);
        // R8: slot free again
        step("R8 new capture", 1, 16'h8000, 4'h2, 1, 0, 0);
        step("R10 far abort", 0, 0, 0, 0, 0, 1);
        step("R10 repeat abort", 1, 16'h8000, 4'h2, 1, 0, 0);
        // R11: disabled window
        dn_base = 16'h3000; dn_limit = 16'h2000;
        step("R11 disabled", 1, 16'h2800, 4'h7, 0, 0, 0);
        step("R11 disabled", 1, 16'h3000, 4'h6, 0, 0, 0);
        dn_base = 16'h1000; dn_limit = 16'h1FFF;
        step("R11 restored", 1, 16'h1FFF, 4'h7, 0, 0, 0);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit st, fd, fm;
            st = ($urandom % 10) < 7;
            fd = (m_st == 1) && ($urandom % 6 == 0);
            fm = (m_st == 1) && !fd && ($urandom % 23 == 0);
            step("rand", st, pool[$urandom % 8], cmds[$urandom % 4], 1'($urandom % 2), fd, fm);
        end
        step("final", 0, 0, 0, 0, 0, 0);
        finish_run();
    end
endmodule